// File: doc/BRIEF.md
# Bit-Reversed Block Feeder

This block sits at the head of a linear pipeline of processing nodes. It streams an endless series of 1024-sample blocks, each read out of a local test-pattern memory in bit-reversed index order, so that the first node can begin a radix-2 decimation-in-time transform stage at once. The test-pattern memory is filled through a simple write port before streaming is enabled.

Each block leaves on one of three downstream links, each made of an 8-bit data bus with a request and an acknowledge line. A block is first offered to the nearest node. If that node stays silent for a fixed number of cycles, the offer moves to the second link and then to the third. Once a node accepts the first word, the rest of the block follows on that same link. When the last word of a block is taken, the next block starts on the following cycle, so consecutive blocks overlap in the pipeline. Each block carries a stage tag of zero, so the node that takes it performs stage one.

The block also gathers the fail outputs of every node into one global stop flag. A silent third link adds a fail of its own. The stop flag holds until reset, and while it is high no request is raised.

The controller has four states. ST_IDLE waits for the stream enable. ST_PROBE offers word 0 of a block and steps through the links on timeout. ST_STREAM moves the remaining words on the chosen link. ST_HALT is the terminal state once stop is up.

The transitions are:

- ST_IDLE→ST_PROBE when the stream enable is high.
- ST_PROBE→ST_STREAM when word 0 is taken.
- ST_PROBE→ST_PROBE on the next link when a link times out.
- ST_PROBE→ST_HALT when the third link times out.
- ST_STREAM→ST_PROBE when the last word is taken and the stream enable is high.
- ST_STREAM→ST_IDLE when the last word is taken and the stream enable is low.
- Any state→ST_HALT once stop is high.

Top module: `bitrev_block_feeder`

## Requirements
- R1: After reset all requests are low, all data buses and the stage tag are zero, and `stop_o` is low.
- R2: The k-th word of every block, counting from 0 to 1023, carries the memory entry at the address formed by reversing the 10 bits of k. For example, word 1 carries entry 512 and word 2 carries entry 256.
- R3: A word moves on a cycle where the request and the acknowledge of the same link are both high. Until then the word stays on its bus. At most one request is high at a time. The data bus of any link without a request is zero.
- R4: When the last word of a block is taken and `stream_en_i` is high, word 0 of the next block is requested on link 0 in the following cycle. If `stream_en_i` is low at that point, all requests drop and the block waits in ST_IDLE.
- R5: A block is offered on link 0 for exactly RETRY_LIMIT cycles (8 by default). Without an acknowledge it is then offered on link 1 for RETRY_LIMIT cycles, then on link 2. Once a link takes word 0, the rest of the block stays on that link with no timeout. Every block starts its offer on link 0. Link index 0 is bit 0 of the request, acknowledge and data vectors.
- R6: If link 2 also times out, `stop_o` is high one cycle later.
- R7: `stop_o` goes high on the cycle after any bit of `node_fail_i` is high. It then stays high until reset.
- R8: While `stop_o` is high, no request is raised and acknowledges have no effect.
- R9: While a request is high, `link_stage_o` carries FIRST_STAGE, which is 0 by default.
- R10: A write through the load port stores `ld_data_i` at the natural index `ld_addr_i`, and the write is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stream_en_i | input | 1 | Allows new blocks to start |
| ld_we_i | input | 1 | Pattern memory write enable |
| ld_addr_i | input | SAMPLE_BITS | Pattern memory write index |
| ld_data_i | input | DATA_W | Pattern memory write data |
| link_req_o | output | NUM_LINKS | Request per downstream link |
| link_ack_i | input | NUM_LINKS | Acknowledge per downstream link |
| link_data_o | output | NUM_LINKS x DATA_W | Data bus per downstream link |
| link_stage_o | output | STAGE_W | Stage tag sent with the block |
| node_fail_i | input | NUM_NODES | Fail outputs of all pipeline nodes |
| stop_o | output | 1 | Latched global failure flag |

## Verification
The assertions assume that acknowledges are only meaningful on a link whose request is high. They also assume that the pattern memory is fully written before the stream enable first rises, so every word read onto a bus is defined. The stimulus loads all 1024 entries while the stream enable is held low. Between fallback scenarios it drops the stream enable and drains the current block, so each fallback test starts from ST_IDLE on link 0. Node fail pulses and the all-silent case are each followed by a reset before further streaming.

// File: rtl/brf_pkg.sv
package brf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_STREAM = 2'd2,
        ST_HALT   = 2'd3
    } feed_state_t;
endpackage

// File: rtl/brf_pattern_mem.sv
module brf_pattern_mem #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/brf_retry_timer.sv
module brf_retry_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] wait_q;

    assign expire = step && (wait_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wait_q <= '0;
        end else if (step) begin
            wait_q <= expire ? '0 : wait_q + 1'b1;
        end
    end
endmodule

// File: rtl/brf_fail_latch.sv
module brf_fail_latch #(
    parameter int NUM_NODES = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_NODES-1:0] node_fail,
    input  logic                 local_fail,
    output logic                 stop
);
    logic stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
        end else begin
            stop_q <= stop_q | (|node_fail) | local_fail;
        end
    end

    assign stop = stop_q;
endmodule

// File: rtl/bitrev_block_feeder.sv
module bitrev_block_feeder
    import brf_pkg::*;
#(
    parameter int SAMPLE_BITS = 10,
    parameter int DATA_W      = 8,
    parameter int NUM_LINKS   = 3,
    parameter int NUM_NODES   = 12,
    parameter int RETRY_LIMIT = 8,
    parameter int STAGE_W     = 4,
    parameter int FIRST_STAGE = 0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              stream_en_i,
    input  logic                              ld_we_i,
    input  logic [SAMPLE_BITS-1:0]            ld_addr_i,
    input  logic [DATA_W-1:0]                 ld_data_i,
    output logic [NUM_LINKS-1:0]              link_req_o,
    input  logic [NUM_LINKS-1:0]              link_ack_i,
    output logic [NUM_LINKS-1:0][DATA_W-1:0]  link_data_o,
    output logic [STAGE_W-1:0]                link_stage_o,
    input  logic [NUM_NODES-1:0]              node_fail_i,
    output logic                              stop_o
);
    localparam int LINK_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;
    localparam int LAST_WORD = (1 << SAMPLE_BITS) - 1;

    feed_state_t             state_q, state_d;
    logic [LINK_W-1:0]       link_q, link_d;
    logic [SAMPLE_BITS-1:0]  cnt_q, cnt_d;
    logic [SAMPLE_BITS-1:0]  rd_addr;
    logic [DATA_W-1:0]       rd_data;
    logic                    stop_w;
    logic                    busy;
    logic                    sel_ack;
    logic                    expire;
    logic                    last_link;
    logic                    last_word;
    logic                    local_fail;

    // read address is the word counter with its bits reversed
    for (genvar b = 0; b < SAMPLE_BITS; b++) begin : g_rev
        assign rd_addr[b] = cnt_q[SAMPLE_BITS-1-b];
    end

    brf_pattern_mem #(.AW(SAMPLE_BITS), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (ld_we_i),
        .waddr (ld_addr_i),
        .wdata (ld_data_i),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign busy      = ((state_q == ST_PROBE) || (state_q == ST_STREAM)) && !stop_w;
    assign sel_ack   = link_ack_i[link_q];
    assign last_link = (link_q == LINK_W'(NUM_LINKS - 1));
    assign last_word = (cnt_q == SAMPLE_BITS'(LAST_WORD));

    brf_retry_timer #(.LIMIT(RETRY_LIMIT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (state_q != ST_PROBE),
        .step   (busy && (state_q == ST_PROBE) && !sel_ack),
        .expire (expire)
    );

    assign local_fail = expire && last_link;

    brf_fail_latch #(.NUM_NODES(NUM_NODES)) u_fail (
        .clk        (clk),
        .rst        (rst),
        .node_fail  (node_fail_i),
        .local_fail (local_fail),
        .stop       (stop_w)
    );

    assign stop_o = stop_w;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            link_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            link_q  <= link_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        link_d  = link_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stop_w) begin
                    state_d = ST_HALT;
                end else if (stream_en_i) begin
                    state_d = ST_PROBE;
                    link_d  = '0;
                    cnt_d   = '0;
                end
            end
            ST_PROBE: begin
                if (stop_w) begin
                    state_d = ST_HALT;
                end else if (sel_ack) begin
                    state_d = ST_STREAM;
                    cnt_d   = cnt_q + 1'b1;
                end else if (expire) begin
                    if (last_link) begin
                        state_d = ST_HALT;
                    end else begin
                        link_d = link_q + 1'b1;
                    end
                end
            end
            ST_STREAM: begin
                if (stop_w) begin
                    state_d = ST_HALT;
                end else if (sel_ack) begin
                    if (last_word) begin
                        cnt_d = '0;
                        if (stream_en_i) begin
                            state_d = ST_PROBE;
                            link_d  = '0;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
        endcase
    end

    // outputs
    always_comb begin
        link_req_o   = '0;
        link_data_o  = '0;
        link_stage_o = '0;
        if (busy) begin
            link_req_o[link_q]  = 1'b1;
            link_data_o[link_q] = rd_data;
            link_stage_o        = STAGE_W'(FIRST_STAGE);
        end
    end
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
    parameter int NUM_LINKS = 3,
    parameter int DATA_W    = 8,
    parameter int NUM_NODES = 12
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_LINKS-1:0]             link_req_o,
    input logic [NUM_LINKS-1:0]             link_ack_i,
    input logic [NUM_LINKS-1:0][DATA_W-1:0] link_data_o,
    input logic [NUM_NODES-1:0]             node_fail_i,
    input logic                             stop_o
);
    // R3
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(link_req_o));

    // R3
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        ((link_req_o != '0) && ((link_req_o & link_ack_i) == '0))
        |=> ((link_req_o != $past(link_req_o)) || $stable(link_data_o)));

    // R5
    to_link1_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_req_o[1]) |-> $past(link_req_o[0]));

    // R5
    to_link2_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_req_o[2]) |-> $past(link_req_o[1]));

    // R7
    node_fail_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (node_fail_i != '0) |=> stop_o);

    // R7
    stop_held_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> stop_o);

    // R8
    quiet_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> (link_req_o == '0));
endmodule

bind bitrev_block_feeder brf_checker #(
    .NUM_LINKS (NUM_LINKS),
    .DATA_W    (DATA_W),
    .NUM_NODES (NUM_NODES)
) u_brf_checker (
    .clk         (clk),
    .rst         (rst),
    .link_req_o  (link_req_o),
    .link_ack_i  (link_ack_i),
    .link_data_o (link_data_o),
    .node_fail_i (node_fail_i),
    .stop_o      (stop_o)
);

// File: tb/bitrev_block_feeder_bench.sv
`timescale 1ns/1ps
module bitrev_block_feeder_bench;
    localparam int SB = 10;
    localparam int DW = 8;
    localparam int NL = 3;
    localparam int NN = 12;
    localparam int LIM = 8;
    localparam int SW = 4;
    localparam int BLK = 1 << SB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stream_en = 1'b0;
    logic ld_we = 1'b0;
    logic [SB-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [NL-1:0] link_req;
    logic [NL-1:0] link_ack = '0;
    logic [NL-1:0][DW-1:0] link_data;
    logic [SW-1:0] link_stage;
    logic [NN-1:0] node_fail = '0;
    logic stop;

    always #2.5 clk = ~clk;

    bitrev_block_feeder u_bitrev_block_feeder (
        .clk(clk), .rst(rst), .stream_en_i(stream_en),
        .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
        .link_req_o(link_req), .link_ack_i(link_ack), .link_data_o(link_data),
        .link_stage_o(link_stage), .node_fail_i(node_fail), .stop_o(stop)
    );

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    logic [NL-1:0] ack_mask = '1;
    bit backpressure = 0;
    logic [DW-1:0] got[$];
    int got_cyc[$];

    function automatic logic [DW-1:0] pat(int i);
        return DW'((i * 37 + 5) & 255);
    endfunction

    function automatic int rev(int k);
        int r = 0;
        for (int b = 0; b < SB; b++) if (k[b]) r |= 1 << (SB - 1 - b);
        return r;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_mode = 0, m_link = 0, m_wait = 0, m_cnt = 0;
    bit m_fail = 0;
    logic [DW-1:0] m_mem [BLK];
    initial for (int i = 0; i < BLK; i++) m_mem[i] = '0;

    always @(posedge clk) begin
        cycle++;
        if (rst) begin
            m_mode = 0; m_link = 0; m_wait = 0; m_cnt = 0; m_fail = 0;
        end else begin
            bit a, nf;
            a = link_ack[m_link];
            nf = 0;
            if (m_fail) m_mode = 3;
            else case (m_mode)
                0: if (stream_en) begin m_mode = 1; m_link = 0; m_cnt = 0; m_wait = 0; end
                1: if (a) begin m_cnt++; m_mode = 2; m_wait = 0; end
                   else if (m_wait == LIM - 1) begin
                       m_wait = 0;
                       if (m_link == NL - 1) begin m_mode = 3; nf = 1; end
                       else m_link++;
                   end else m_wait++;
                2: if (a) begin
                       if (m_cnt == BLK - 1) begin
                           m_cnt = 0;
                           if (stream_en) begin m_mode = 1; m_link = 0; end
                           else m_mode = 0;
                       end else m_cnt++;
                   end
                default: ;
            endcase
            m_fail = m_fail | nf | (node_fail != '0);
        end
        if (ld_we) m_mem[ld_addr] = ld_data;
    end

    // per-cycle comparison, well clear of both edges
    always begin
        @(negedge clk);
        #2;
        if (!rst) begin
            logic [NL-1:0] e_req;
            logic [NL-1:0][DW-1:0] e_data;
            bit busy;
            busy = (m_mode == 1 || m_mode == 2) && !m_fail;
            e_req = '0;
            e_data = '0;
            if (busy) begin
                e_req[m_link] = 1'b1;
                e_data[m_link] = m_mem[rev(m_cnt)];
            end
            check(link_req == e_req, "R5 request vector", link_req, e_req);
            check(link_data == e_data, "R2 data buses", link_data, e_data);
            check(stop == m_fail, "R7 stop flag", stop, m_fail);
            check(link_stage == (busy ? SW'(0) : SW'(0)), "R9 stage tag", link_stage, 0);
            for (int k = 0; k < NL; k++)
                if (link_req[k] && link_ack[k]) begin
                    got.push_back(link_data[k]);
                    got_cyc.push_back(cycle);
                end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
        link_ack = ack_mask & (backpressure ? NL'($urandom) : {NL{1'b1}});
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        run(3);
        check(link_req == '0 && link_data == '0 && stop == 1'b0 && link_stage == '0,
              "R1 reset outputs", {link_req, stop}, 0);
        rst = 1'b0;
        ack_mask = '0;
        for (int i = 0; i < BLK; i++) begin
            tick();
            ld_we = 1'b1; ld_addr = SB'(i); ld_data = pat(i);
        end
        tick();
        ld_we = 1'b0;

        // continuous acceptance on link 0
        ack_mask = 3'b001;
        stream_en = 1'b1;
        while (got.size() < BLK + 20) tick();
        check(got[0] == pat(0), "R10 loaded word 0", got[0], pat(0));
        check(got[1] == pat(512), "R2 word 1 from entry 512", got[1], pat(512));
        check(got[2] == pat(256), "R2 word 2 from entry 256", got[2], pat(256));
        check(got[BLK-1] == pat(BLK-1), "R2 last word", got[BLK-1], pat(BLK-1));
        check(got[BLK] == pat(0), "R4 next block word 0", got[BLK], pat(0));
        check(got_cyc[BLK] - got_cyc[BLK-1] == 1, "R4 back to back blocks",
              got_cyc[BLK] - got_cyc[BLK-1], 1);

        // random acknowledge pattern
        backpressure = 1;
        ack_mask = 3'b111;
        run(1500);
        backpressure = 0;
        stream_en = 1'b0;
        run(BLK + 20);
        check(link_req == '0, "R4 idle when not enabled", link_req, 0);

        // link 0 silent: fallback to link 1
        ack_mask = 3'b010;
        stream_en = 1'b1;
        n0 = 0;
        for (int i = 0; i < 100; i++) begin
            tick();
            if (link_req[1]) break;
            if (link_req[0]) n0++;
        end
        check(n0 == LIM, "R5 cycles offered on link 0", n0, LIM);
        stream_en = 1'b0;
        run(40);
        check(link_req == 3'b010, "R5 block stays on link 1", link_req, 3'b010);
        run(BLK + 20);

        // links 0 and 1 silent: fallback to link 2
        ack_mask = 3'b100;
        stream_en = 1'b1;
        run(3 * LIM + 3);
        stream_en = 1'b0;
        check(link_req == 3'b100, "R5 block reaches link 2", link_req, 3'b100);
        run(BLK + 20);

        // all links silent
        ack_mask = 3'b000;
        stream_en = 1'b1;
        run(3 * LIM + 3);
        check(stop == 1'b1, "R6 stop after three timeouts", stop, 1);
        ack_mask = 3'b111;
        run(10);
        check(stop == 1'b1 && link_req == '0, "R8 quiet while stopped", {stop, link_req}, 4'b1000);

        // node fail pulse during streaming
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        run(50);
        node_fail = NN'(1) << 5;
        tick();
        node_fail = '0;
        tick();
        check(stop == 1'b1, "R7 stop after node fail", stop, 1);
        run(20);
        check(stop == 1'b1 && link_req == '0, "R8 stop latched, no request", {stop, link_req}, 4'b1000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule